// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a 12-bit current-output converter. Each cycle it samples a set of level-sensitive, active-low controls and moves data through two stages. The first stage is an input latch made of two sections: an upper 8-bit section and a lower 4-bit section. A word-select input chooses whether a write fills all twelve bits or only the lower four. The second stage is the converter register, which drives the analog ladder. It takes a copy of the whole input latch only while its own pair of strobes is asserted.

Because the two stages are strobed independently, a new code can be assembled in the input latch while the converter keeps its old value. Software can write the upper byte and lower nibble in separate bus cycles, then move the finished code in one transfer. Each stage follows its input on every clock while its enable holds, and keeps its value otherwise. When both stages are enabled in the same cycle, the value being written passes straight through to the converter register.

Top module: `dac_dbl_buffer`

## Requirements
- R1: While `rst` is high at a clock edge, both `latchOut` and `dacOut` become zero after that edge.
- R2: The input latch changes only at an edge where `csN` and `wrLatchN` are both low. At any other edge `latchOut` keeps its value, whatever `dataIn` and `fullWordSel` do.
- R3: At an edge where the input latch is enabled and `fullWordSel` is 1, all twelve bits of `latchOut` take the value of `dataIn`.
- R4: At an edge where the input latch is enabled and `fullWordSel` is 0, only `latchOut[3:0]` takes `dataIn[3:0]`, and `latchOut[11:4]` keeps its previous value.
- R5: The converter register changes only at an edge where `wrXferN` and `xferN` are both low. At any other edge `dacOut` is unchanged. `csN` has no effect on this path.
- R6: At an edge where the transfer is enabled, `dacOut` takes the input-latch value that results from that same edge. If the latch is also written at that edge, the new data appears on `dacOut` in the same cycle.
- R7: Bit order is preserved: `dataIn[0]` is the LSB and `dataIn[11]` the MSB on both outputs. An all-ones code gives full-scale output and an all-zeros code gives zero output.
- R8: A full write of A, then a low-nibble write of B, then a transfer leaves `dacOut` = {A[11:4], B[3:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low; gates the input-latch write |
| wrLatchN | input | 1 | Input-latch write strobe, active low |
| wrXferN | input | 1 | Transfer write strobe, active low |
| xferN | input | 1 | Transfer control, active low |
| fullWordSel | input | 1 | 1: write all 12 bits; 0: write low nibble only |
| dataIn | input | 12 | Data code, bit 0 LSB |
| latchOut | output | 12 | Current input-latch contents |
| dacOut | output | 12 | Converter register value |

## Verification
The bench runs the split-write sequence with distinct byte and nibble values, so that a lost or wrongly merged section shows on `dacOut`. It writes with only chip select or only the write strobe low, and transfers with only one of the two transfer strobes low. These runs separate a correct two-input gate from a single-input one. It enables write and transfer together to tell a pass-through from a one-cycle-late copy, and it moves the latch while transfers are held off to prove isolation. A long run of mixed random strobes then compares both outputs with a behavioural model on every clock.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;
  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic xfer;
  } dacStrobes_t;
endpackage

// File: rtl/dacbuf_ctrl.sv
module dacbuf_ctrl
  import dacbuf_pkg::*;
(
  input  logic        csN,
  input  logic        wrLatchN,
  input  logic        wrXferN,
  input  logic        xferN,
  input  logic        fullWordSel,
  output dacStrobes_t strobes
);
  logic latchEn;

  always_comb begin
    latchEn          = ~csN & ~wrLatchN;
    strobes.loadLow  = latchEn;
    strobes.loadHigh = latchEn & fullWordSel;
    strobes.xfer     = ~wrXferN & ~xferN;
  end
endmodule

// File: rtl/dacbuf_datapath.sv
module dacbuf_datapath
  import dacbuf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LOW_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dacStrobes_t       strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] latchQ,
  output logic [DATA_W-1:0] dacQ
);
  localparam int HIGH_W = DATA_W - LOW_W;
  localparam int NUM_SEC = 2;

  logic [NUM_SEC-1:0] secEn;
  logic [DATA_W-1:0]  latchNext;

  assign secEn[0] = strobes.loadLow;
  assign secEn[1] = strobes.loadHigh;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    localparam int BASE = (s == 0) ? 0 : LOW_W;
    localparam int WID  = (s == 0) ? LOW_W : HIGH_W;
    logic [WID-1:0] secQ;

    always_ff @(posedge clk) begin
      if (rst)
        secQ <= '0;
      else if (secEn[s])
        secQ <= dataIn[BASE +: WID];
    end

    assign latchNext[BASE +: WID] = secEn[s] ? dataIn[BASE +: WID] : secQ;
    assign latchQ[BASE +: WID]    = secQ;
  end

  always_ff @(posedge clk) begin
    if (rst)
      dacQ <= '0;
    else if (strobes.xfer)
      dacQ <= latchNext;
  end
endmodule

// File: rtl/dac_dbl_buffer.sv
module dac_dbl_buffer
  import dacbuf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LOW_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              wrLatchN,
  input  logic              wrXferN,
  input  logic              xferN,
  input  logic              fullWordSel,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] latchOut,
  output logic [DATA_W-1:0] dacOut
);
  dacStrobes_t strobes;

  dacbuf_ctrl u_ctrl (
    .csN         (csN),
    .wrLatchN    (wrLatchN),
    .wrXferN     (wrXferN),
    .xferN       (xferN),
    .fullWordSel (fullWordSel),
    .strobes     (strobes)
  );

  dacbuf_datapath #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .dataIn  (dataIn),
    .latchQ  (latchOut),
    .dacQ    (dacOut)
  );
endmodule

// File: rtl/dacbuf_checker.sv
module dacbuf_checker #(
  parameter int DATA_W = 12,
  parameter int LOW_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              csN,
  input logic              wrLatchN,
  input logic              wrXferN,
  input logic              xferN,
  input logic              fullWordSel,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] latchOut,
  input logic [DATA_W-1:0] dacOut
);
  logic wrOn, xfOn;
  assign wrOn = !csN && !wrLatchN;
  assign xfOn = !wrXferN && !xferN;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (latchOut == '0 && dacOut == '0));

  a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !wrOn |=> $stable(latchOut));

  a_r3_full_write: assert property (@(posedge clk) disable iff (rst)
    (wrOn && fullWordSel) |=> latchOut == $past(dataIn));

  a_r4_nibble_write: assert property (@(posedge clk) disable iff (rst)
    (wrOn && !fullWordSel) |=>
      (latchOut[DATA_W-1:LOW_W] == $past(latchOut[DATA_W-1:LOW_W]) &&
       latchOut[LOW_W-1:0] == $past(dataIn[LOW_W-1:0])));

  a_r5_dac_hold: assert property (@(posedge clk) disable iff (rst)
    !xfOn |=> $stable(dacOut));

  a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
    xfOn |=> dacOut == latchOut);
endmodule

bind dac_dbl_buffer dacbuf_checker #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst(rst), .csN(csN), .wrLatchN(wrLatchN), .wrXferN(wrXferN),
  .xferN(xferN), .fullWordSel(fullWordSel), .dataIn(dataIn),
  .latchOut(latchOut), .dacOut(dacOut)
);

// File: tb/tb_dac_dbl_buffer.sv
`timescale 1ns/1ps
module tb_dac_dbl_buffer;
  logic clk = 0, rst = 1;
  logic csN = 1, wrLatchN = 1, wrXferN = 1, xferN = 1, fullWordSel = 1;
  logic [11:0] dataIn = '0;
  logic [11:0] latchOut, dacOut;

  int checks = 0, failures = 0;
  int refLatch = 0, refDac = 0;
  bit done = 0, modelOn = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  dac_dbl_buffer dut (.*);

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      refLatch = 0; refDac = 0;
    end else begin
      if (!csN && !wrLatchN) begin
        if (fullWordSel) refLatch = dataIn;
        else refLatch = (refLatch & 'hFF0) | (dataIn & 'hF);
      end
      if (!wrXferN && !xferN) refDac = refLatch;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (modelOn && !done) begin
    chk({phase, " latch vs model"}, latchOut, refLatch);
    chk({phase, " dac vs model"}, dacOut, refDac);
  end

  task automatic cyc(bit c, bit w1, bit w2, bit x, bit s, logic [11:0] d);
    csN = c; wrLatchN = w1; wrXferN = w2; xferN = x; fullWordSel = s; dataIn = d;
    @(posedge clk); #1;
  endtask

  task automatic idle(logic [11:0] d);
    cyc(1, 1, 1, 1, 1, d);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1; failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 latch reset", latchOut, 0);
    chk("R1 dac reset", dacOut, 0);
    rst = 0; modelOn = 1;

    phase = "R8";
    cyc(0, 0, 1, 1, 1, 12'hA5C);
    cyc(0, 0, 1, 1, 0, 12'h3F7);
    chk("R8 latch merged", latchOut, 'hA57);
    chk("R5 dac untouched before xfer", dacOut, 0);
    cyc(1, 1, 0, 0, 1, 12'h000);
    chk("R8 dac merged", dacOut, 'hA57);

    phase = "R2";
    cyc(1, 0, 1, 1, 1, 12'h111);
    chk("R2 cs high holds", latchOut, 'hA57);
    cyc(0, 1, 1, 1, 1, 12'h222);
    chk("R2 wr high holds", latchOut, 'hA57);

    phase = "R3";
    cyc(0, 0, 1, 1, 1, 12'h6B2);
    chk("R3 full write", latchOut, 'h6B2);
    chk("R5 latch change not transferred", dacOut, 'hA57);

    phase = "R5";
    cyc(0, 1, 0, 1, 1, 12'h0);
    chk("R5 only wrXfer low", dacOut, 'hA57);
    cyc(0, 1, 1, 0, 1, 12'h0);
    chk("R5 only xfer low", dacOut, 'hA57);
    cyc(1, 1, 0, 0, 1, 12'h0);
    chk("R5 cs ignored on transfer", dacOut, 'h6B2);

    phase = "R4";
    cyc(0, 0, 1, 1, 0, 12'hFF9);
    chk("R4 nibble write", latchOut, 'h6B9);

    phase = "R6";
    cyc(0, 0, 0, 0, 1, 12'hD3E);
    chk("R6 pass-through full", dacOut, 'hD3E);
    cyc(0, 0, 0, 0, 0, 12'h001);
    chk("R6 pass-through nibble", dacOut, 'hD31);

    phase = "R7";
    cyc(0, 0, 0, 0, 1, 12'h001);
    chk("R7 lsb position", dacOut, 'h001);
    cyc(0, 0, 0, 0, 1, 12'h800);
    chk("R7 msb position", dacOut, 'h800);
    cyc(0, 0, 0, 0, 1, 12'hFFF);
    chk("R7 all ones full scale", dacOut, 'hFFF);
    cyc(0, 0, 0, 0, 1, 12'h000);
    chk("R7 all zeros", dacOut, 'h000);

    phase = "R2/R5 random";
    for (int i = 0; i < 2000; i++) begin
      logic [16:0] r;
      r = 17'($urandom);
      cyc(r[0] & r[1], r[2] & r[3], r[4], r[5] & r[6], r[7], 12'(r >> 5));
    end

    phase = "R1";
    cyc(0, 0, 1, 1, 1, 12'h5A5);
    rst = 1;
    idle(12'h0);
    chk("R1 reset again latch", latchOut, 0);
    chk("R1 reset again dac", dacOut, 0);
    rst = 0;
    idle(12'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule